// File: doc/BRIEF.md
# ADC Sample Ring Buffer with Host-Owned Read Pointer

This block holds converted ADC samples in a circular store whose depth is not a power of two. The default depth is 2003 entries. A producer presents one sample per cycle. The block writes it at the write index and advances that index, wrapping explicitly from the last slot back to 0. The host reads samples through a separate indexed read port. It tracks its own read position and, once it has consumed data, writes the new read index into a register. The block derives occupancy from the two indices.

Three sticky event flags report conditions to the host:
- a fill-level flag, set when occupancy reaches a host-programmed threshold (default half the depth, 1001);
- an overrun flag, set when an incoming sample has to be discarded because the store is full;
- a hardware-fault flag, driven by an external fault input.

A per-bit enable register gates these flags onto a single registered interrupt line. The host clears flags by writing ones to them.

Top module: `smp_ring_top`

## Requirements
- R1: The write index runs over 0..DEPTH-1 (DEPTH=2003 by default); an accepted sample written at index DEPTH-1 makes the next write index 0.
- R2: With `smp_valid` high at a clock edge and the store not full, `smp_data` is stored at the current write index and the index advances by one; the sample at `rd_idx` appears on `rd_data` one clock edge later.
- R3: A register write to address 1 sets the read index when the value is below DEPTH; a value of DEPTH or more is ignored and the read index keeps its previous value.
- R4: Register address 2 returns occupancy = write index minus read index, plus DEPTH when that difference is negative; address 0 returns the write index and address 1 the read index.
- R5: The store is full when advancing the write index would make it equal to the read index (DEPTH-1 entries held); a sample offered while full is discarded, the write index stays unchanged, and flag bit 1 (overrun) is set on that edge.
- R6: Flag bit 0 is set on the clock edge after the one where occupancy first reaches or exceeds the threshold register (address 3, reset value DEPTH/2 = 1001); a threshold of 0 never sets it.
- R7: `hw_fault` high at a clock edge sets flag bit 2.
- R8: Flags (address 4, bits 2..0) hold their value until the host writes 1 to a bit at address 4; if the set condition of a bit is true on the same edge as its clear, the set wins.
- R9: The enable register (address 5, bits 2..0) gates the flags. `irq` is a register loaded each edge with the OR of (flags AND enable), so it follows a flag or enable change one edge later. An enable of 0 keeps `irq` low.
- R10: After reset the write and read indices, occupancy, flags, enable and `irq` are 0 and the threshold is 1001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Producer offers a sample this cycle |
| smp_data | input | DW (16) | Sample value |
| hw_fault | input | 1 | Converter hardware fault event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 write idx, 1 read idx, 2 occupancy, 3 threshold, 4 flags, 5 enable) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_addr`) |
| rd_idx | input | PW (11) | Sample read index |
| rd_data | output | DW (16) | Sample at `rd_idx`, registered |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench fills the store to DEPTH-1 entries and offers one more sample. A full test that is off by one would either overwrite the oldest unread slot or refuse a sample one entry early. It then moves the read index to the last slot and writes across the wrap point. This exposes a design that wraps at a power of two, and it checks the occupancy formula when the write index is below the read index. Threshold timing, a clear that collides with a live set condition, and a read-index write of DEPTH are each aimed at a specific mistake. In order, these are a flag on the wrong edge, a lost event, and a corrupted read index. The enable tests show that `irq` lags an enable change by exactly one edge and stays low for flags whose enable bit is off.

// File: rtl/smp_ring_pkg.sv
package smp_ring_pkg;

  localparam int unsigned FLAG_W  = 3;
  localparam int unsigned FLG_THR = 0;
  localparam int unsigned FLG_OVR = 1;
  localparam int unsigned FLG_HW  = 2;

  typedef enum logic [2:0] {
    RA_WIDX  = 3'd0,
    RA_RIDX  = 3'd1,
    RA_OCC   = 3'd2,
    RA_THR   = 3'd3,
    RA_FLAGS = 3'd4,
    RA_EN    = 3'd5
  } reg_addr_e;

  // Next slot index with explicit wrap for any depth.
  function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Entries held between write index and read index.
  function automatic int unsigned ring_occ(int unsigned widx, int unsigned ridx,
                                           int unsigned depth);
    return (widx >= ridx) ? (widx - ridx) : (widx + depth - ridx);
  endfunction

endpackage

// File: rtl/smp_ring_mem.sv
module smp_ring_mem #(
  parameter int DEPTH = 2003,
  parameter int DW    = 16,
  parameter int PW    = 11
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
    if (32'(rd_idx) < DEPTH) rd_data <= store[rd_idx];
    else                     rd_data <= '0;
  end
endmodule

// File: rtl/smp_ring_ptrs.sv
module smp_ring_ptrs
  import smp_ring_pkg::*;
#(
  parameter int DEPTH = 2003,
  parameter int PW    = 11,
  parameter int RW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          ridx_we,
  input  logic [RW-1:0] ridx_wdata,
  output logic [PW-1:0] widx,
  output logic [PW-1:0] ridx,
  output logic [PW-1:0] occ,
  output logic          wr_accept,
  output logic          wr_drop
);
  logic [PW-1:0] widx_q, ridx_q, widx_nxt;
  logic          full;
  logic          ridx_ok;

  assign widx_nxt  = PW'(ring_next(32'(widx_q), DEPTH));
  assign full      = (widx_nxt == ridx_q);
  assign wr_accept = wr_req && !full;
  assign wr_drop   = wr_req && full;
  assign ridx_ok   = (32'(ridx_wdata) < DEPTH);
  assign occ       = PW'(ring_occ(32'(widx_q), 32'(ridx_q), DEPTH));
  assign widx      = widx_q;
  assign ridx      = ridx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widx_q <= '0;
      ridx_q <= '0;
    end else begin
      if (wr_accept)          widx_q <= widx_nxt;
      if (ridx_we && ridx_ok) ridx_q <= PW'(ridx_wdata);
    end
  end

  assert_widx_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && widx_q == PW'(DEPTH-1)) |=> widx_q == '0);
  assert_widx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(widx_q) < DEPTH);
  assert_ridx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ridx_q) < DEPTH);
  assert_bad_ridx_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ridx_we && !ridx_ok) |=> $stable(ridx_q));
  assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ) <= DEPTH-1);
  assert_drop_holds_widx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> $stable(widx_q));
endmodule

// File: rtl/smp_ring_flags.sv
module smp_ring_flags
  import smp_ring_pkg::*;
#(
  parameter int PW       = 11,
  parameter int RW       = 16,
  parameter int THR_INIT = 1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     occ,
  input  logic              ovr_evt,
  input  logic              hw_evt,
  input  logic              thr_we,
  input  logic [RW-1:0]     thr_wdata,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_bits,
  input  logic              en_we,
  input  logic [FLAG_W-1:0] en_wdata,
  output logic [RW-1:0]     thresh,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] enable,
  output logic              irq
);
  logic [RW-1:0]     thr_q;
  logic [FLAG_W-1:0] flags_q, en_q, set_v, clr_v;
  logic              thr_hit, irq_q;

  assign thr_hit = (thr_q != '0) && (32'(occ) >= 32'(thr_q));

  always_comb begin
    set_v          = '0;
    set_v[FLG_THR] = thr_hit;
    set_v[FLG_OVR] = ovr_evt;
    set_v[FLG_HW]  = hw_evt;
    clr_v          = clr_we ? clr_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q   <= RW'(THR_INIT);
      flags_q <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (thr_we) thr_q <= thr_wdata;
      if (en_we)  en_q  <= en_wdata;
      flags_q <= (flags_q & ~clr_v) | set_v;
      irq_q   <= |(flags_q & en_q);
    end
  end

  assign thresh = thr_q;
  assign flags  = flags_q;
  assign enable = en_q;
  assign irq    = irq_q;

  assert_ovr_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> flags_q[FLG_OVR]);
  assert_thr_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hit |=> flags_q[FLG_THR]);
  assert_hw_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |=> flags_q[FLG_HW]);
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[FLG_OVR] && !(clr_we && clr_bits[FLG_OVR])) |=> flags_q[FLG_OVR]);
  assert_en_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_q);
endmodule

// File: rtl/smp_ring_top.sv
module smp_ring_top
  import smp_ring_pkg::*;
#(
  parameter  int DEPTH = 2003,
  parameter  int DW    = 16,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          hw_fault,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int RW       = 16;
  localparam int THR_INIT = DEPTH / 2;

  logic [PW-1:0]     widx, ridx, occ;
  logic              wr_accept, wr_drop;
  logic [RW-1:0]     thresh;
  logic [FLAG_W-1:0] flags, enable;
  reg_addr_e         ra;

  assign ra = reg_addr_e'(reg_addr);

  smp_ring_ptrs #(.DEPTH(DEPTH), .PW(PW), .RW(RW)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .wr_req(smp_valid),
    .ridx_we(reg_we && ra == RA_RIDX), .ridx_wdata(reg_wdata),
    .widx(widx), .ridx(ridx), .occ(occ),
    .wr_accept(wr_accept), .wr_drop(wr_drop)
  );

  smp_ring_mem #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) mem_i (
    .clk(clk), .wr_en(wr_accept), .wr_idx(widx), .wr_data(smp_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  smp_ring_flags #(.PW(PW), .RW(RW), .THR_INIT(THR_INIT)) flags_i (
    .clk(clk), .rst_n(rst_n), .occ(occ),
    .ovr_evt(wr_drop), .hw_evt(hw_fault),
    .thr_we(reg_we && ra == RA_THR), .thr_wdata(reg_wdata),
    .clr_we(reg_we && ra == RA_FLAGS), .clr_bits(reg_wdata[FLAG_W-1:0]),
    .en_we(reg_we && ra == RA_EN), .en_wdata(reg_wdata[FLAG_W-1:0]),
    .thresh(thresh), .flags(flags), .enable(enable), .irq(irq)
  );

  always_comb begin
    case (ra)
      RA_WIDX:  reg_rdata = RW'(widx);
      RA_RIDX:  reg_rdata = RW'(ridx);
      RA_OCC:   reg_rdata = RW'(occ);
      RA_THR:   reg_rdata = thresh;
      RA_FLAGS: reg_rdata = RW'(flags);
      RA_EN:    reg_rdata = RW'(enable);
      default:  reg_rdata = '0;
    endcase
  end

  assert_accept_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && widx != PW'(DEPTH-1)) |=> widx == $past(widx) + 1'b1);
endmodule

// File: tb/smp_ring_top_tb_top.sv
`timescale 1ns/1ps
module smp_ring_top_tb_top;
  localparam int DEPTH = 2003;
  localparam int DW    = 16;
  localparam int PW    = $clog2(DEPTH);

  logic          clk = 0, rst_n = 0;
  logic          smp_valid = 0, hw_fault = 0, reg_we = 0;
  logic [DW-1:0] smp_data = '0;
  logic [2:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0, reg_rdata;
  logic [PW-1:0] rd_idx = '0;
  logic [DW-1:0] rd_data;
  logic          irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  smp_ring_top #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .hw_fault(hw_fault), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_idx(rd_idx),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string req, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; smp_valid = 0; hw_fault = 0; reg_we = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic rd_reg(int a, output int v);
    reg_addr = 3'(a); #1; v = int'(reg_rdata);
  endtask

  task automatic wr_reg(int a, int d);
    reg_addr = 3'(a); reg_wdata = 16'(d); reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic push(int n, int base);
    for (int i = 0; i < n; i++) begin
      smp_data = DW'(base + i); smp_valid = 1;
      @(negedge clk);
    end
    smp_valid = 0;
  endtask

  task automatic rd_smp(int idx, output int v);
    rd_idx = PW'(idx); @(negedge clk); v = int'(rd_data);
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd_reg(0, v); chk("R10 widx", v, 0);
    rd_reg(1, v); chk("R10 ridx", v, 0);
    rd_reg(2, v); chk("R10 occ", v, 0);
    rd_reg(3, v); chk("R10 thresh", v, 1001);
    rd_reg(4, v); chk("R10 flags", v, 0);
    rd_reg(5, v); chk("R10 enable", v, 0);
    chk("R10 irq", int'(irq), 0);
  endtask

  task automatic t_write_read();
    int v;
    do_reset();
    push(3, 16'hA001);
    rd_reg(0, v); chk("R2 widx", v, 3);
    rd_reg(2, v); chk("R4 occ", v, 3);
    rd_smp(1, v); chk("R2 data", v, 16'hA002);
    rd_smp(0, v); chk("R2 data0", v, 16'hA001);
  endtask

  task automatic t_ridx();
    int v;
    do_reset();
    push(5, 100);
    wr_reg(1, 3);
    rd_reg(1, v); chk("R3 ridx", v, 3);
    rd_reg(2, v); chk("R4 occ", v, 2);
    wr_reg(1, DEPTH);
    rd_reg(1, v); chk("R3 ignore", v, 3);
    wr_reg(1, 5);
    rd_reg(2, v); chk("R4 empty", v, 0);
  endtask

  task automatic t_full_wrap();
    int v;
    do_reset();
    push(DEPTH-1, 0);
    rd_reg(0, v); chk("R5 widx full", v, DEPTH-1);
    rd_reg(2, v); chk("R4 occ full", v, DEPTH-1);
    rd_reg(4, v); chk("R6 thr flag", v, 1);
    push(1, 16'h7777);
    rd_reg(0, v); chk("R5 widx held", v, DEPTH-1);
    rd_reg(4, v); chk("R5 overrun", v, 3);
    rd_smp(DEPTH-2, v); chk("R5 data kept", v, DEPTH-2);
    wr_reg(4, 2);
    rd_reg(4, v); chk("R8 w1c", v, 1);
    wr_reg(1, DEPTH-1);
    rd_reg(2, v); chk("R4 occ zero", v, 0);
    push(1, 16'hBEEF);
    rd_reg(0, v); chk("R1 wrap", v, 0);
    rd_reg(2, v); chk("R4 neg occ", v, 1);
    rd_smp(DEPTH-1, v); chk("R1 last slot", v, 16'hBEEF);
    push(1, 16'h1234);
    rd_reg(0, v); chk("R1 after wrap", v, 1);
    rd_reg(2, v); chk("R4 neg occ2", v, 2);
    rd_smp(0, v); chk("R2 slot0", v, 16'h1234);
  endtask

  task automatic t_thresh();
    int v;
    do_reset();
    wr_reg(3, 4);
    push(3, 0);
    @(negedge clk);
    rd_reg(4, v); chk("R6 below", v, 0);
    push(1, 3);
    rd_reg(4, v); chk("R6 not yet", v, 0);
    @(negedge clk);
    rd_reg(4, v); chk("R6 set", v, 1);
    wr_reg(4, 1);
    rd_reg(4, v); chk("R8 set wins", v, 1);
    wr_reg(1, 2);
    wr_reg(4, 1);
    rd_reg(4, v); chk("R8 cleared", v, 0);
    wr_reg(3, 0);
    wr_reg(1, 4);
    @(negedge clk); @(negedge clk);
    rd_reg(4, v); chk("R6 zero thr", v, 0);
  endtask

  task automatic t_irq();
    int v;
    do_reset();
    hw_fault = 1; @(negedge clk); hw_fault = 0;
    rd_reg(4, v); chk("R7 hw flag", v, 4);
    @(negedge clk); @(negedge clk);
    chk("R9 masked", int'(irq), 0);
    wr_reg(5, 4);
    chk("R9 lag", int'(irq), 0);
    @(negedge clk);
    chk("R9 on", int'(irq), 1);
    wr_reg(5, 3);
    @(negedge clk);
    chk("R9 other bits", int'(irq), 0);
    wr_reg(5, 4);
    @(negedge clk);
    chk("R9 on again", int'(irq), 1);
    wr_reg(4, 4);
    rd_reg(4, v); chk("R8 hw clear", v, 0);
    @(negedge clk);
    chk("R9 off after clear", int'(irq), 0);
    wr_reg(5, 0);
    hw_fault = 1; @(negedge clk); hw_fault = 0;
    @(negedge clk); @(negedge clk);
    chk("R9 disabled", int'(irq), 0);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_ridx();
    t_full_wrap();
    t_thresh();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule